// File: doc/BRIEF.md
# Memory-Mapped Port Multiplexer with Broadcast

This block links a single memory-mapped host bus to an array of `N` identical slave ports. Each port owns a window of `2^A` words. The host word address splits into two parts. The bits above `A` form a port index. The low `A` bits pass unchanged to the port as its local register offset. In decode mode the port index routes each read or write strobe to exactly one port. The block registers the index of each read, so the data and the valid strobe that return one cycle later come from that same port.

In broadcast mode a single host write reaches every port in the same cycle, which lets one access program a whole array of identical register banks. Reads in this mode always come from port 0, and no other port can be read. The mode is a build-time parameter. The slave register banks sit outside the block and answer a read strobe with data one clock later.

Top module: `mm_port_mux`

## Requirements
- R1: In decode mode, a host word address `a` selects port `a >> A`. The low `A` bits of `a` appear unchanged on that port's address field, which is bits `[i*A +: A]` of `p_addr` for port `i`.
- R2: In decode mode, a write to port `i < N` raises `p_wr[i]` alone, in the same cycle. The host write data appears on that port's slice `[i*DW +: DW]` of `p_wdata`.
- R3: In decode mode, a read to port `i < N` raises `p_rd[i]` alone. One cycle later `host_rvalid` is 1 and `host_rdata` carries that port's returned data. If no read was issued in the previous cycle, `host_rvalid` is 0 and `host_rdata` is 0.
- R4: In decode mode, at most one bit of `p_wr` and at most one bit of `p_rd` is high in any cycle. The strobes of ports that are not selected stay low.
- R5: In decode mode, a write whose port index is `N` or more drives no bit of `p_wr`.
- R6: In decode mode, a read whose port index is `N` or more drives no bit of `p_rd`. One cycle later `host_rvalid` is 1 and `host_rdata` is 0.
- R7: In broadcast mode, a host write raises every bit of `p_wr` in the same cycle, whatever the upper address bits are. All ports receive the same low address bits and the same data.
- R8: In broadcast mode, a host read raises only `p_rd[0]`, whatever the upper address bits are. One cycle later the data returned by port 0 appears on `host_rdata`.
- R9: While `rst` is high, and in the first cycle after it, `host_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | IDX_W+A | Host word address (port index above, offset below) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data, one cycle after the read |
| host_rvalid | output | 1 | Read data valid |
| p_addr | output | N*A | Per-port local word offset |
| p_wr | output | N | Per-port write strobe |
| p_rd | output | N | Per-port read strobe |
| p_wdata | output | N*DW | Per-port write data |
| p_rdata | input | N*DW | Per-port read data, one cycle after its strobe |
| p_rvalid | input | N | Per-port read data valid |

## Verification
A wrong decode shows up in the same cycle, as a strobe on the wrong port or as two strobes at once. A stale or corrupted registered read index shows up one cycle after the read, as data from a neighbouring port, or as nonzero data for an unmapped address. Both builds are driven through every host address for writes and then for reads. Because the register contents depend on the address, any misrouted write or read return shows a value that differs from the one the bench computes.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

    typedef enum logic {
        MODE_DECODE    = 1'b0,
        MODE_BROADCAST = 1'b1
    } mmx_mode_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } mmx_cmd_t;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mmx_decode.sv
module mmx_decode
    import mmx_pkg::*;
#(
    parameter int        N     = 3,
    parameter int        IDX_W = 2,
    parameter mmx_mode_e MODE  = MODE_DECODE
) (
    input  logic [IDX_W-1:0] idx,
    input  mmx_cmd_t         cmd,
    output logic [N-1:0]     wr_sel,
    output logic [N-1:0]     rd_sel,
    output logic [IDX_W-1:0] rd_port,
    output logic             rd_miss
);
    localparam logic [31:0] N_U = 32'(N);

    logic in_range;

    always_comb begin
        in_range = (32'(idx) < N_U);
        wr_sel   = '0;
        rd_sel   = '0;
        if (MODE == MODE_BROADCAST) begin
            wr_sel    = {N{cmd.wr}};
            rd_sel[0] = cmd.rd;
            rd_port   = '0;
            rd_miss   = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                wr_sel[i] = cmd.wr && (idx == IDX_W'(i));
                rd_sel[i] = cmd.rd && (idx == IDX_W'(i));
            end
            rd_port = idx;
            rd_miss = !in_range;
        end
    end
endmodule

// File: rtl/mmx_fanout.sv
module mmx_fanout #(
    parameter int N  = 3,
    parameter int A  = 2,
    parameter int DW = 32
) (
    input  logic [A-1:0]    ofs,
    input  logic [DW-1:0]   wdata,
    input  logic [N-1:0]    wr_sel,
    input  logic [N-1:0]    rd_sel,
    output logic [N*A-1:0]  p_addr,
    output logic [N*DW-1:0] p_wdata,
    output logic [N-1:0]    p_wr,
    output logic [N-1:0]    p_rd
);
    for (genvar g = 0; g < N; g++) begin : g_port
        assign p_addr[g*A +: A]    = ofs;
        assign p_wdata[g*DW +: DW] = wdata;
        assign p_wr[g]             = wr_sel[g];
        assign p_rd[g]             = rd_sel[g];
    end
endmodule

// File: rtl/mmx_rdret.sv
module mmx_rdret #(
    parameter int N     = 3,
    parameter int IDX_W = 2,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_issue,
    input  logic [IDX_W-1:0] rd_port,
    input  logic             rd_miss,
    input  logic [N*DW-1:0]  p_rdata,
    input  logic [N-1:0]     p_rvalid,
    output logic [DW-1:0]    host_rdata,
    output logic             host_rvalid
);
    logic             pend_q;
    logic             miss_q;
    logic [IDX_W-1:0] port_q;
    logic [DW-1:0]    sel_data;
    logic             sel_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            miss_q <= 1'b0;
            port_q <= '0;
        end else begin
            pend_q <= rd_issue;
            if (rd_issue) begin
                miss_q <= rd_miss;
                port_q <= rd_port;
            end
        end
    end

    always_comb begin
        sel_data = '0;
        sel_vld  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (port_q == IDX_W'(i)) begin
                sel_data = p_rdata[i*DW +: DW];
                sel_vld  = p_rvalid[i];
            end
        end
        host_rvalid = pend_q && (miss_q || sel_vld);
        host_rdata  = (pend_q && !miss_q) ? sel_data : '0;
    end
endmodule

// File: rtl/mm_port_mux.sv
module mm_port_mux
    import mmx_pkg::*;
#(
    parameter int        N     = 3,
    parameter int        A     = 2,
    parameter int        DW    = 32,
    parameter mmx_mode_e MODE  = MODE_DECODE,
    localparam int       IDX_W = idx_bits(N),
    localparam int       HAW   = IDX_W + A
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HAW-1:0]  host_addr,
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic            host_rvalid,
    output logic [N*A-1:0]  p_addr,
    output logic [N-1:0]    p_wr,
    output logic [N-1:0]    p_rd,
    output logic [N*DW-1:0] p_wdata,
    input  logic [N*DW-1:0] p_rdata,
    input  logic [N-1:0]    p_rvalid
);
    mmx_cmd_t         cmd;
    logic [N-1:0]     wr_sel;
    logic [N-1:0]     rd_sel;
    logic [IDX_W-1:0] rd_port;
    logic             rd_miss;

    assign cmd = '{wr: host_wr, rd: host_rd};

    mmx_decode #(.N(N), .IDX_W(IDX_W), .MODE(MODE)) u_dec (
        .idx     (host_addr[HAW-1:A]),
        .cmd     (cmd),
        .wr_sel  (wr_sel),
        .rd_sel  (rd_sel),
        .rd_port (rd_port),
        .rd_miss (rd_miss)
    );

    mmx_fanout #(.N(N), .A(A), .DW(DW)) u_fan (
        .ofs     (host_addr[A-1:0]),
        .wdata   (host_wdata),
        .wr_sel  (wr_sel),
        .rd_sel  (rd_sel),
        .p_addr  (p_addr),
        .p_wdata (p_wdata),
        .p_wr    (p_wr),
        .p_rd    (p_rd)
    );

    mmx_rdret #(.N(N), .IDX_W(IDX_W), .DW(DW)) u_ret (
        .clk         (clk),
        .rst         (rst),
        .rd_issue    (host_rd),
        .rd_port     (rd_port),
        .rd_miss     (rd_miss),
        .p_rdata     (p_rdata),
        .p_rvalid    (p_rvalid),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );
endmodule

// File: rtl/mm_port_mux_chk.sv
module mm_port_mux_chk
    import mmx_pkg::*;
#(
    parameter int        N     = 3,
    parameter int        A     = 2,
    parameter int        DW    = 32,
    parameter mmx_mode_e MODE  = MODE_DECODE,
    localparam int       IDX_W = idx_bits(N),
    localparam int       HAW   = IDX_W + A
) (
    input logic           clk,
    input logic           rst,
    input logic [HAW-1:0] host_addr,
    input logic           host_wr,
    input logic           host_rd,
    input logic [DW-1:0]  host_rdata,
    input logic           host_rvalid,
    input logic [N-1:0]   p_wr,
    input logic [N-1:0]   p_rd
);
    localparam logic [31:0] N_U = 32'(N);

    a_r3_no_spurious_rvalid: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !host_rvalid);
    a_r3_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        !host_rvalid |-> host_rdata == '0);

    if (MODE == MODE_DECODE) begin : g_dec
        logic addr_hit;
        assign addr_hit = 32'(host_addr[HAW-1:A]) < N_U;

        a_r4_wr_onehot: assert property (@(posedge clk) disable iff (rst)
            $onehot0(p_wr));
        a_r4_rd_onehot: assert property (@(posedge clk) disable iff (rst)
            $onehot0(p_rd));
        a_r2_wr_reaches_one: assert property (@(posedge clk) disable iff (rst)
            host_wr && addr_hit |-> $countones(p_wr) == 1);
        a_r5_miss_no_wr: assert property (@(posedge clk) disable iff (rst)
            host_wr && !addr_hit |-> p_wr == '0);
        a_r6_miss_rd_zero: assert property (@(posedge clk) disable iff (rst)
            host_rd && !addr_hit |=> host_rvalid && host_rdata == '0);
    end else begin : g_bc
        a_r7_bcast_all_wr: assert property (@(posedge clk) disable iff (rst)
            host_wr |-> &p_wr);
        a_r8_bcast_rd_port0: assert property (@(posedge clk) disable iff (rst)
            host_rd |-> p_rd[0] && $countones(p_rd) == 1);
    end
endmodule

bind mm_port_mux mm_port_mux_chk #(.N(N), .A(A), .DW(DW), .MODE(MODE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .p_wr        (p_wr),
    .p_rd        (p_rd)
);

// File: tb/mm_port_mux_tb.sv
module mm_port_mux_tb;
    import mmx_pkg::*;

    localparam int CLK_NS = 10;
    localparam int N      = 3;
    localparam int A      = 2;
    localparam int DW     = 32;
    localparam int HAW    = 4;
    localparam int NADDR  = 1 << HAW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [HAW-1:0] host_addr = '0;
    logic host_wr = 1'b0;
    logic host_rd = 1'b0;
    logic [DW-1:0] host_wdata = '0;

    logic [DW-1:0]   d_rdata, b_rdata;
    logic            d_rvalid, b_rvalid;
    logic [N*A-1:0]  d_paddr, b_paddr;
    logic [N-1:0]    d_pwr, b_pwr, d_prd, b_prd, d_prv, b_prv;
    logic [N*DW-1:0] d_pwd, b_pwd, d_prdata, b_prdata;

    logic [DW-1:0] mem_d [N][4];
    logic [DW-1:0] mem_b [N][4];

    int nvec = 0;
    int nbad = 0;

    always #(CLK_NS/2) clk = ~clk;

    mm_port_mux #(.N(N), .A(A), .DW(DW), .MODE(MODE_DECODE)) u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(d_rdata),
        .host_rvalid(d_rvalid), .p_addr(d_paddr), .p_wr(d_pwr), .p_rd(d_prd),
        .p_wdata(d_pwd), .p_rdata(d_prdata), .p_rvalid(d_prv));

    mm_port_mux #(.N(N), .A(A), .DW(DW), .MODE(MODE_BROADCAST)) u_dut_bcast (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(b_rdata),
        .host_rvalid(b_rvalid), .p_addr(b_paddr), .p_wr(b_pwr), .p_rd(b_prd),
        .p_wdata(b_pwd), .p_rdata(b_prdata), .p_rvalid(b_prv));

    // Slave register banks: one-cycle read latency
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                for (int r = 0; r < 4; r++) begin
                    mem_d[i][r] <= '0;
                    mem_b[i][r] <= '0;
                end
                d_prv[i] <= 1'b0;
                b_prv[i] <= 1'b0;
                d_prdata[i*DW +: DW] <= '0;
                b_prdata[i*DW +: DW] <= '0;
            end else begin
                if (d_pwr[i]) mem_d[i][d_paddr[i*A +: A]] <= d_pwd[i*DW +: DW];
                if (b_pwr[i]) mem_b[i][b_paddr[i*A +: A]] <= b_pwd[i*DW +: DW];
                d_prv[i] <= d_prd[i];
                b_prv[i] <= b_prd[i];
                d_prdata[i*DW +: DW] <= mem_d[i][d_paddr[i*A +: A]];
                b_prdata[i*DW +: DW] <= mem_b[i][b_paddr[i*A +: A]];
            end
        end
    end

    function automatic logic [DW-1:0] val_of(input int a);
        return 32'hC0DE_0000 + 32'(a) * 32'h0001_0011;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int a);
        int idx = a >> A;
        @(negedge clk);
        host_addr  = HAW'(a);
        host_wdata = val_of(a);
        host_wr    = 1'b1;
        #1;
        chk("R2/R4/R5 decode p_wr", 32'(d_pwr), (idx < N) ? (32'd1 << idx) : 32'd0);
        if (idx < N) begin
            chk("R1 decode offset", 32'(d_paddr[idx*A +: A]), 32'(a % 4));
            chk("R2 decode wdata", d_pwd[idx*DW +: DW], val_of(a));
        end
        chk("R7 broadcast p_wr", 32'(b_pwr), 32'(3'b111));
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_read(input int a);
        int idx = a >> A;
        @(negedge clk);
        #1;
        chk("R3 idle rvalid decode", 32'(d_rvalid), 32'd0);
        chk("R3 idle rdata decode", d_rdata, 32'd0);
        host_addr = HAW'(a);
        host_rd   = 1'b1;
        #1;
        chk("R3/R4/R6 decode p_rd", 32'(d_prd), (idx < N) ? (32'd1 << idx) : 32'd0);
        chk("R8 broadcast p_rd", 32'(b_prd), 32'd1);
        @(negedge clk);
        host_rd = 1'b0;
        #1;
        chk("R3/R6 decode rvalid", 32'(d_rvalid), 32'd1);
        chk("R3/R6 decode rdata", d_rdata, (idx < N) ? val_of(a) : 32'd0);
        chk("R8 broadcast rvalid", 32'(b_rvalid), 32'd1);
        chk("R8 broadcast rdata", b_rdata, val_of(12 + a % 4));
    endtask

    initial begin
        #(CLK_NS * 50000);
        nbad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 rvalid in reset decode", 32'(d_rvalid), 32'd0);
        chk("R9 rvalid in reset bcast", 32'(b_rvalid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 rvalid after reset", 32'({d_rvalid, b_rvalid}), 32'd0);
        chk("R4 strobes idle", 32'({d_pwr, d_prd, b_pwr, b_prd}), 32'd0);

        for (int a = 0; a < NADDR; a++) do_write(a);
        @(negedge clk);
        for (int p = 0; p < N; p++)
            for (int r = 0; r < 4; r++)
                chk("R7 broadcast bank content", mem_b[p][r], val_of(12 + r));
        for (int a = 0; a < NADDR; a++) do_read(a);
        for (int a = NADDR - 1; a >= 0; a--) do_read(a);

        @(negedge clk);
        #1;
        chk("R3 rvalid after last read", 32'({d_rvalid, b_rvalid}), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule